// File: doc/BRIEF.md
# Load Queue Ordering-Violation Detector

This block is the load side of a speculative memory pipeline. A load may read the cache before every older store has produced its address. The design assumes that those stores will not touch the same location. Each load gets a slot at dispatch and carries a sequence number (its age). Address generation later fills in the slot's address. The slot is marked performed once the load has read the cache. A slot is released from the head, in program order, when its load retires.

When a store resolves its address, the block searches every occupied slot in parallel. It looks for loads that are younger than the store, that already hold an address and have performed, and that read the same address. Each such load got a stale value. The block then raises a flush request naming the oldest such load. The request is held until the pipeline accepts it. On acceptance the queue drops that load and everything younger by pulling its tail back.

The control is a two-state machine. `LQ_WATCH` is the normal state. A search hit moves it to `LQ_HOLD`. While in `LQ_HOLD`, a new hit on a load older than the held one replaces the held report. `flush_ack` returns the machine to `LQ_WATCH`. Allocation is refused while the machine is in `LQ_HOLD`.

Top module: `lq_violation_detect`

## Requirements
- R1: After reset the queue is empty (`lq_count` = 0), `flush_req` is low and `alloc_ready` is high.
- R2: An accepted allocation writes the slot given by `alloc_idx`. Slots are handed out in increasing index order, modulo DEPTH, and `lq_count` rises by one. When `lq_count` equals DEPTH, `alloc_ready` is low and `alloc_valid` has no effect.
- R3: A `retire_valid` cycle frees the oldest slot and lowers `lq_count` by one.
- R4: In the cycle after a `st_valid` cycle, `flush_req` is high when some occupied load meets all of these conditions: it is younger than `st_age`, its address has been written, it has performed, and its address equals `st_addr`. In that case `flush_age` and `flush_idx` name that load.
- R5: A store search ignores loads that are older than the store, loads that have not performed, and slots whose address has not been written since allocation. A stale address left in a slot by an earlier load does not count.
- R6: A perform mark given through `perf_valid`/`perf_idx` in the same cycle as a store search counts as already performed for that search.
- R7: When several loads qualify, the oldest one is reported. While a request is pending, a later hit on an older load replaces the report, and a hit on a younger load leaves it unchanged.
- R8: `flush_req` stays high until `flush_ack`. One cycle after an accepted `flush_ack`, `flush_req` is low. `lq_count` then equals the number of loads older than the reported one, and the next allocation uses `flush_idx`.
- R9: While `flush_req` is high, `alloc_ready` is low and `alloc_valid` does not change `lq_count`.
- R10: Ages are SEQ_W-bit wrapping counters. Age a is younger than age b when (a - b) mod 2^SEQ_W lies between 1 and 2^(SEQ_W-1) - 1. Because of this, the comparison stays correct when the counter rolls over.
- R11: `flush_req` never rises without a store search in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch a load into the queue |
| alloc_age | input | SEQ_W | Age of the dispatched load |
| alloc_ready | output | 1 | Queue can take a load this cycle |
| alloc_idx | output | log2(DEPTH) | Slot the next load will occupy |
| agen_valid | input | 1 | Write an address into a slot |
| agen_idx | input | log2(DEPTH) | Slot receiving the address |
| agen_addr | input | ADDR_W | Load address |
| perf_valid | input | 1 | Mark a slot as performed |
| perf_idx | input | log2(DEPTH) | Slot that performed |
| st_valid | input | 1 | A store resolved its address; search the queue |
| st_age | input | SEQ_W | Age of the resolving store |
| st_addr | input | ADDR_W | Address of the resolving store |
| retire_valid | input | 1 | Free the head slot |
| flush_ack | input | 1 | Pipeline accepts the pending flush |
| flush_req | output | 1 | Ordering violation pending |
| flush_age | output | SEQ_W | Age of the oldest violating load |
| flush_idx | output | log2(DEPTH) | Slot of the oldest violating load |
| lq_count | output | log2(DEPTH)+1 | Occupied slots |

## Verification
The assertions assume that the surrounding pipeline behaves legally:
- `retire_valid` is never given on an empty queue.
- The slot named in a pending flush is never retired before `flush_ack`.
- A store search never coincides with `flush_ack`.
- All in-flight ages stay within half the counter range.

The stimulus respects each of these. Every retire matches a load the bench model knows is present. Acknowledgement is issued only as a separate operation. Store ages are chosen close to the load ages around them, even across the counter rollover.

// File: rtl/lq_pkg.sv
package lq_pkg;

    // Flush controller states
    typedef enum logic [0:0] {
        LQ_WATCH = 1'b0,   // no violation pending
        LQ_HOLD  = 1'b1    // flush request raised, waiting for acceptance
    } lq_state_e;

endpackage

// File: rtl/lq_ptrs.sv
module lq_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             cut,
    input  logic [IDX_W-1:0] cut_idx,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    logic [IDX_W-1:0] head_n;

    always_comb begin
        head_n = head + IDX_W'(pop);
        full   = (count == CNT_W'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head <= head_n;
            if (cut) begin
                // tail pulled back to the flushed slot; it and all younger go away
                tail  <= cut_idx;
                count <= {1'b0, IDX_W'(cut_idx - head_n)};
            end else begin
                tail  <= tail + IDX_W'(push);
                count <= count + CNT_W'(push) - CNT_W'(pop);
            end
        end
    end

endmodule

// File: rtl/lq_cam.sv
module lq_cam #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0]              head,
    input  logic [CNT_W-1:0]              count,
    input  logic [DEPTH-1:0][SEQ_W-1:0]   ent_age,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    input  logic [DEPTH-1:0]              ent_av,
    input  logic [DEPTH-1:0]              ent_pf,
    input  logic                          perf_valid,
    input  logic [IDX_W-1:0]              perf_idx,
    input  logic                          st_valid,
    input  logic [SEQ_W-1:0]              st_age,
    input  logic [ADDR_W-1:0]             st_addr,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx,
    output logic [SEQ_W-1:0]              hit_age
);

    // a younger than b under modular sequence arithmetic
    function automatic logic is_younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [IDX_W-1:0] rel;
        logic             pf_eff;
        assign rel      = IDX_W'(g) - head;
        assign occ[g]   = ({1'b0, rel} < count);
        assign pf_eff   = ent_pf[g] | (perf_valid && (perf_idx == IDX_W'(g)));
        assign match[g] = st_valid && occ[g] && ent_av[g] && pf_eff
                          && (ent_addr[g] == st_addr)
                          && is_younger(ent_age[g], st_age);
    end

    // oldest match = first set bit walking from the head
    always_comb begin
        logic [IDX_W-1:0] j;
        hit_idx = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            j = head + IDX_W'(k);
            if (match[j]) begin
                hit_idx = j;
            end
        end
        hit     = |match;
        hit_age = ent_age[hit_idx];
    end

endmodule

// File: rtl/lq_flush_fsm.sv
module lq_flush_fsm
    import lq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [SEQ_W-1:0] hit_age,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             ack,
    output logic             flush_req,
    output logic [SEQ_W-1:0] flush_age,
    output logic [IDX_W-1:0] flush_idx
);

    function automatic logic is_younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    lq_state_e        state_q, state_d;
    logic [SEQ_W-1:0] age_q, age_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LQ_WATCH;
            age_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            age_q   <= age_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        age_d   = age_q;
        idx_d   = idx_q;
        unique case (state_q)
            LQ_WATCH: begin
                if (hit) begin
                    state_d = LQ_HOLD;
                    age_d   = hit_age;
                    idx_d   = hit_idx;
                end
            end
            LQ_HOLD: begin
                if (ack) begin
                    state_d = LQ_WATCH;
                end else if (hit && is_younger(age_q, hit_age)) begin
                    age_d = hit_age;
                    idx_d = hit_idx;
                end
            end
            default: state_d = LQ_WATCH;
        endcase
    end

    // outputs
    always_comb begin
        flush_req = (state_q == LQ_HOLD);
        flush_age = age_q;
        flush_idx = idx_q;
    end

endmodule

// File: rtl/lq_violation_detect.sv
module lq_violation_detect
    import lq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_age,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              agen_valid,
    input  logic [IDX_W-1:0]  agen_idx,
    input  logic [ADDR_W-1:0] agen_addr,
    input  logic              perf_valid,
    input  logic [IDX_W-1:0]  perf_idx,
    input  logic              st_valid,
    input  logic [SEQ_W-1:0]  st_age,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              retire_valid,
    input  logic              flush_ack,
    output logic              flush_req,
    output logic [SEQ_W-1:0]  flush_age,
    output logic [IDX_W-1:0]  flush_idx,
    output logic [CNT_W-1:0]  lq_count
);

    logic [DEPTH-1:0][SEQ_W-1:0]  e_age;
    logic [DEPTH-1:0][ADDR_W-1:0] e_addr;
    logic [DEPTH-1:0]             e_av;
    logic [DEPTH-1:0]             e_pf;

    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             push, cut;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [SEQ_W-1:0] hit_age;

    always_comb begin
        alloc_ready = !full && !flush_req;
        push        = alloc_valid && alloc_ready;
        cut         = flush_req && flush_ack;
        alloc_idx   = tail;
        lq_count    = count;
    end

    // slot storage
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_age[g]  <= '0;
                e_addr[g] <= '0;
                e_av[g]   <= 1'b0;
                e_pf[g]   <= 1'b0;
            end else if (push && (tail == IDX_W'(g))) begin
                e_age[g] <= alloc_age;
                e_av[g]  <= 1'b0;
                e_pf[g]  <= 1'b0;
            end else begin
                if (agen_valid && (agen_idx == IDX_W'(g))) begin
                    e_addr[g] <= agen_addr;
                    e_av[g]   <= 1'b1;
                end
                if (perf_valid && (perf_idx == IDX_W'(g))) begin
                    e_pf[g] <= 1'b1;
                end
            end
        end
    end

    lq_ptrs #(.DEPTH(DEPTH)) ptrs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (retire_valid),
        .cut     (cut),
        .cut_idx (flush_idx),
        .head    (head),
        .tail    (tail),
        .count   (count),
        .full    (full)
    );

    lq_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) cam_i (
        .head       (head),
        .count      (count),
        .ent_age    (e_age),
        .ent_addr   (e_addr),
        .ent_av     (e_av),
        .ent_pf     (e_pf),
        .perf_valid (perf_valid),
        .perf_idx   (perf_idx),
        .st_valid   (st_valid),
        .st_age     (st_age),
        .st_addr    (st_addr),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_age    (hit_age)
    );

    lq_flush_fsm #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .hit_age   (hit_age),
        .hit_idx   (hit_idx),
        .ack       (flush_ack),
        .flush_req (flush_req),
        .flush_age (flush_age),
        .flush_idx (flush_idx)
    );

endmodule

// File: rtl/lq_violation_detect_chk.sv
module lq_violation_detect_chk #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic             retire_valid,
    input logic             st_valid,
    input logic             flush_ack,
    input logic             flush_req,
    input logic [SEQ_W-1:0] flush_age,
    input logic [CNT_W-1:0] lq_count
);

    function automatic logic is_younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        lq_count <= CNT_W'(DEPTH));

    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_count == CNT_W'(DEPTH)) |-> !alloc_ready);

    a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !retire_valid && !(flush_req && flush_ack))
        |=> (lq_count == $past(lq_count) + CNT_W'(1)));

    a_r3_retire_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && !alloc_valid && !flush_req)
        |=> (lq_count == $past(lq_count) - CNT_W'(1)));

    a_r7_report_never_younger: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> !is_younger(flush_age, $past(flush_age)));

    a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_ack) |=> !flush_req);

    a_r9_hold_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !alloc_ready);

    a_r11_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_req && !st_valid) |=> !flush_req);

endmodule

bind lq_violation_detect lq_violation_detect_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .retire_valid (retire_valid),
    .st_valid     (st_valid),
    .flush_ack    (flush_ack),
    .flush_req    (flush_req),
    .flush_age    (flush_age),
    .lq_count     (lq_count)
);

// File: tb/lq_violation_detect_tb_top.sv
`timescale 1ns/1ps
module lq_violation_detect_tb_top;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;
    localparam int SEQ_W  = 5;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [SEQ_W-1:0]  alloc_age = '0;
    logic              alloc_ready;
    logic [IDX_W-1:0]  alloc_idx;
    logic              agen_valid = 1'b0;
    logic [IDX_W-1:0]  agen_idx = '0;
    logic [ADDR_W-1:0] agen_addr = '0;
    logic              perf_valid = 1'b0;
    logic [IDX_W-1:0]  perf_idx = '0;
    logic              st_valid = 1'b0;
    logic [SEQ_W-1:0]  st_age = '0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic              retire_valid = 1'b0;
    logic              flush_ack = 1'b0;
    logic              flush_req;
    logic [SEQ_W-1:0]  flush_age;
    logic [IDX_W-1:0]  flush_idx;
    logic [CNT_W-1:0]  lq_count;

    always #2 clk = ~clk;

    lq_violation_detect #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_age(alloc_age), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .agen_valid(agen_valid), .agen_idx(agen_idx), .agen_addr(agen_addr),
        .perf_valid(perf_valid), .perf_idx(perf_idx),
        .st_valid(st_valid), .st_age(st_age), .st_addr(st_addr),
        .retire_valid(retire_valid), .flush_ack(flush_ack),
        .flush_req(flush_req), .flush_age(flush_age), .flush_idx(flush_idx), .lq_count(lq_count)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // reference model of the queue
    logic [SEQ_W-1:0]  m_age  [DEPTH];
    logic [ADDR_W-1:0] m_addr [DEPTH];
    bit                m_av   [DEPTH];
    bit                m_pf   [DEPTH];
    int                m_head = 0;
    int                m_cnt  = 0;
    bit                m_pend = 1'b0;
    logic [SEQ_W-1:0]  m_page = '0;
    int                m_pidx = 0;
    logic [SEQ_W-1:0]  seq    = '0;

    typedef struct {
        int    due;
        string tag;
        bit    req;
        int    age;
        int    idx;
        int    cnt;
    } exp_t;
    exp_t sbq[$];

    function automatic bit yng(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        e.due = cyc + 1;
        e.tag = tag;
        e.req = m_pend;
        e.age = int'(m_page);
        e.idx = m_pidx;
        e.cnt = m_cnt;
        sbq.push_back(e);
    endtask

    // monitor: compares registered outputs one cycle after each driven operation
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            chk(flush_req == e.req, {e.tag, " flush_req"}, int'(flush_req), int'(e.req));
            if (e.req) begin
                chk(int'(flush_age) == e.age, {e.tag, " flush_age"}, int'(flush_age), e.age);
                chk(int'(flush_idx) == e.idx, {e.tag, " flush_idx"}, int'(flush_idx), e.idx);
            end
            chk(int'(lq_count) == e.cnt, {e.tag, " lq_count"}, int'(lq_count), e.cnt);
        end
    end

    task automatic cyc_end();
        @(negedge clk);
        alloc_valid  = 1'b0;
        agen_valid   = 1'b0;
        perf_valid   = 1'b0;
        st_valid     = 1'b0;
        retire_valid = 1'b0;
        flush_ack    = 1'b0;
    endtask

    task automatic do_alloc(output int idx);
        int t;
        t = (m_head + m_cnt) % DEPTH;
        chk(alloc_ready == 1'b1, "R2 alloc_ready", int'(alloc_ready), 1);
        chk(int'(alloc_idx) == t, "R2 alloc_idx", int'(alloc_idx), t);
        alloc_valid = 1'b1;
        alloc_age   = seq;
        m_age[t] = seq;
        m_av[t]  = 1'b0;
        m_pf[t]  = 1'b0;
        m_cnt++;
        seq++;
        idx = t;
        push_exp("R2 alloc");
        cyc_end();
    endtask

    task automatic do_agen(input int i, input logic [ADDR_W-1:0] a);
        agen_valid = 1'b1;
        agen_idx   = IDX_W'(i);
        agen_addr  = a;
        m_addr[i]  = a;
        m_av[i]    = 1'b1;
        push_exp("R4 agen");
        cyc_end();
    endtask

    task automatic do_perf(input int i);
        perf_valid = 1'b1;
        perf_idx   = IDX_W'(i);
        m_pf[i]    = 1'b1;
        push_exp("R4 perform");
        cyc_end();
    endtask

    task automatic do_store(input logic [SEQ_W-1:0] age, input logic [ADDR_W-1:0] a,
                            input int pi, input string tag);
        int hit;
        st_valid = 1'b1;
        st_age   = age;
        st_addr  = a;
        if (pi >= 0) begin
            perf_valid = 1'b1;
            perf_idx   = IDX_W'(pi);
            m_pf[pi]   = 1'b1;
        end
        hit = -1;
        for (int k = 0; k < m_cnt; k++) begin
            int j;
            j = (m_head + k) % DEPTH;
            if (hit < 0 && m_av[j] && m_pf[j] && m_addr[j] == a && yng(m_age[j], age)) hit = j;
        end
        if (hit >= 0) begin
            if (!m_pend || yng(m_page, m_age[hit])) begin
                m_pend = 1'b1;
                m_page = m_age[hit];
                m_pidx = hit;
            end
        end
        push_exp(tag);
        cyc_end();
    endtask

    task automatic do_retire();
        retire_valid = 1'b1;
        m_head = (m_head + 1) % DEPTH;
        m_cnt--;
        push_exp("R3 retire");
        cyc_end();
    endtask

    task automatic do_ack();
        flush_ack = 1'b1;
        if (m_pend) begin
            m_cnt  = (m_pidx - m_head + DEPTH) % DEPTH;
            m_pend = 1'b0;
        end
        push_exp("R8 ack");
        cyc_end();
    endtask

    task automatic do_blocked_alloc(input string tag);
        alloc_valid = 1'b1;
        alloc_age   = seq;
        push_exp(tag);
        cyc_end();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int l0, l1, l2, l3, l4, l5, la, lb, tmp;
        logic [SEQ_W-1:0] sa, sb, sx, sy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(lq_count == '0, "R1 lq_count", int'(lq_count), 0);
        chk(flush_req == 1'b0, "R1 flush_req", int'(flush_req), 0);
        chk(alloc_ready == 1'b1, "R1 alloc_ready", int'(alloc_ready), 1);

        // phase A: several loads, then out-of-order store resolutions
        sa = seq; seq++;
        do_alloc(l0);
        do_alloc(l1);
        sb = seq; seq++;
        do_alloc(l2);
        do_alloc(l3);
        do_agen(l0, 32'h100);
        do_agen(l1, 32'h200);
        do_agen(l2, 32'h100);
        do_agen(l3, 32'h300);
        do_perf(l0);
        do_perf(l1);
        do_perf(l2);
        do_store(sb, 32'h100, -1, "R4 younger performed load hit, R5 older skipped");
        chk(alloc_ready == 1'b0, "R9 alloc_ready while pending", int'(alloc_ready), 0);
        do_blocked_alloc("R9 alloc ignored while pending");
        do_perf(l3);
        do_store(5'(seq + 5'd1), 32'h300, -1, "R5 older load ignored");
        do_store(sa, 32'h200, -1, "R7 older hit replaces report");
        do_store(sb, 32'h300, -1, "R7 younger hit leaves report");
        do_ack();
        chk(flush_req == 1'b0, "R8 flush_req after ack", int'(flush_req), 0);

        // phase B: unperformed, stale address, same-cycle perform
        do_alloc(l4);
        do_agen(l4, 32'h400);
        do_store(5'(seq - 5'd2), 32'h400, -1, "R5 unperformed load ignored");
        do_alloc(l5);
        do_store(5'(seq - 5'd3), 32'h100, -1, "R5 stale address ignored");
        do_store(5'(seq - 5'd3), 32'h400, l4, "R6 same-cycle perform hit");
        do_ack();
        do_retire();

        // phase C: fill to full and drain
        for (int i = 0; i < DEPTH; i++) do_alloc(tmp);
        chk(alloc_ready == 1'b0, "R2 alloc_ready when full", int'(alloc_ready), 0);
        do_blocked_alloc("R2 alloc ignored when full");
        for (int i = 0; i < DEPTH; i++) do_retire();

        // phase D: ages across counter rollover
        while (seq != 5'd30) begin
            do_alloc(tmp);
            do_retire();
        end
        sx = seq; seq++;
        do_alloc(la);
        sy = seq; seq++;
        do_alloc(lb);
        do_agen(la, 32'hA0);
        do_agen(lb, 32'hA0);
        do_perf(la);
        do_perf(lb);
        do_store(sy, 32'hA0, -1, "R10 rollover: older load skipped, younger hit");
        do_store(sx, 32'hA0, -1, "R10 R7 rollover older hit replaces");
        do_ack();

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule